// File: doc/BRIEF.md
# Six-Channel Triggered-Update PWM

This block generates up to six independent pulse-width-modulated outputs from one clock. Each channel has a clock divider, a period length and an active-time length. Software programs these values through a small synchronous write/read port. Every write lands in a shadow copy. A channel's running waveform only changes when software raises that channel's commit bit.

A per-channel selector bit picks when a commit takes effect. With the selector set, the new settings wait for the end of the current period, so the waveform is never cut short. With the selector clear, they take effect after a fixed settling delay counted in clock cycles.

The block has no enable control. A channel is silenced by committing a period of zero. While a channel's commit bit and selector bit are both low, its pin is held high. Each pin can be driven push-pull or as an open-drain output, which only pulls low.

Top module: `pwm_bank`

## Requirements
- R1: The control word at byte address 0x00 holds, for channel n, the commit bit at bit n, polarity at bit 8+n, drive type at bit 16+n and the boundary-selector at bit 24+n. All other bits read back as 0.
- R2: The divider word at 0x04 holds a 3-bit field per channel at bits [4n+2:4n]; the other bits read 0. The period of channel n is at 0x08+8n and its active time at 0x0C+8n, both 24 bits wide with the upper bits reading 0. Unmapped addresses read 0. Read data appears one clock after the address is presented.
- R3: Writes to divider, period, active time and polarity change no output until a rising edge of that channel's commit bit. A commit bit that is held high causes no further commit.
- R4: If the selector is 0 when the commit bit rises, the new settings first appear on the pin at the clock edge SETTLE_CYC+2 after the edge that captured the write. At the edge before that, the old waveform is still shown.
- R5: If the selector is 1 when the commit bit rises, the old waveform runs until its current period ends, and the new settings start at that boundary.
- R6: From the first clock edge after a channel's commit bit and selector are both 0, and for as long as both stay 0, its pin is 1.
- R7: With a period P of at least 2 and a divider D, the waveform repeats every (D+1)*P clocks. It is active for (D+1)*min(H,P) clocks of each repetition, where H is the active time; H of 0 gives no active clocks.
- R8: Polarity 1 makes the active level 1. Polarity 0 inverts the pin.
- R9: A committed period below 2 makes the pin constantly inactive.
- R10: Drive type 1 gives an output enable that is always 1. Drive type 0 sets the output enable to 1 only while the pin is 0.
- R11: Reset clears every register. After reset all pins are 1, all output enables are 0, and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for addr |
| pwm_out | output | NCH | Registered PWM pin level per channel |
| pwm_oe | output | NCH | Registered output enable per channel |

## Verification
The case where a boundary-timed commit and the period-counter wrap fall in the same cycle needs care. The bench first starts a 100-clock waveform with 60 active clocks. It then raises the commit bit with the selector set just as a period begins, with an idle setting waiting in the shadow registers. The pin must stay active well past the settling delay, which shows that no early commit happened. It must then be low at a point where the old waveform would have been active again, which shows the load happened exactly at the wrap. The fast-commit path is judged on its exact edge, and the pin is sampled at the edges on either side of it.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  parameter int CNT_W = 24;
  parameter int PRE_W = 3;
  parameter int DW    = 32;
  parameter int GRP   = 8;   // bit stride between control groups

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] high;
    logic             pol;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH-1:0]    trig,
  output logic [NCH-1:0]    pol,
  output logic [NCH-1:0]    otype,
  output logic [NCH-1:0]    smooth,
  output chan_cfg_t         shadow [NCH]
);
  localparam int CTRL_A  = 0;
  localparam int PRE_A   = 4;
  localparam int CH_BASE = 8;
  localparam int CH_STEP = 8;
  localparam int PRE_STEP = 4;

  logic [PRE_W-1:0] pre_r  [NCH];
  logic [CNT_W-1:0] per_r  [NCH];
  logic [CNT_W-1:0] high_r [NCH];
  logic [DW-1:0]    rd_nxt;

  wire wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_A));
  wire wr_pre  = wr_en && (addr == ADDR_W'(PRE_A));

  always_ff @(posedge clk) begin
    if (rst) begin
      trig <= '0; pol <= '0; otype <= '0; smooth <= '0;
    end else if (wr_ctrl) begin
      trig   <= wdata[0*GRP +: NCH];
      pol    <= wdata[1*GRP +: NCH];
      otype  <= wdata[2*GRP +: NCH];
      smooth <= wdata[3*GRP +: NCH];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire wr_per  = wr_en && (addr == ADDR_W'(CH_BASE + CH_STEP*c));
    wire wr_high = wr_en && (addr == ADDR_W'(CH_BASE + CH_STEP*c + 4));

    always_ff @(posedge clk) begin
      if (rst) begin
        pre_r[c]  <= '0;
        per_r[c]  <= '0;
        high_r[c] <= '0;
      end else begin
        if (wr_pre)  pre_r[c]  <= wdata[PRE_STEP*c +: PRE_W];
        if (wr_per)  per_r[c]  <= wdata[CNT_W-1:0];
        if (wr_high) high_r[c] <= wdata[CNT_W-1:0];
      end
    end

    always_comb begin
      shadow[c].pre  = pre_r[c];
      shadow[c].per  = per_r[c];
      shadow[c].high = high_r[c];
      shadow[c].pol  = pol[c];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (addr == ADDR_W'(CTRL_A)) begin
      rd_nxt[0*GRP +: NCH] = trig;
      rd_nxt[1*GRP +: NCH] = pol;
      rd_nxt[2*GRP +: NCH] = otype;
      rd_nxt[3*GRP +: NCH] = smooth;
    end
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(PRE_A))
        rd_nxt[PRE_STEP*c +: PRE_W] = pre_r[c];
      if (addr == ADDR_W'(CH_BASE + CH_STEP*c))
        rd_nxt = DW'(per_r[c]);
      if (addr == ADDR_W'(CH_BASE + CH_STEP*c + 4))
        rd_nxt = DW'(high_r[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int SETTLE_CYC = 20
) (
  input  logic      clk,
  input  logic      rst,
  input  chan_cfg_t shadow,
  input  logic      trig,
  input  logic      smooth,
  input  logic      otype,
  output logic      pin_q,
  output logic      oe_q
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  chan_cfg_t        act;
  logic             trig_d;
  logic             pend_s;
  logic [SW-1:0]    settle;
  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic             level;

  wire              rise     = trig & ~trig_d;
  wire              tick     = (pcnt == act.pre);
  wire [CNT_W:0]    nxt      = {1'b0, cnt} + 1'b1;
  wire              boundary = tick && (nxt >= {1'b0, act.per});
  wire              commit   = (settle == SW'(1)) || (pend_s && boundary);
  wire              forced   = ~smooth & ~trig;
  wire              active   = (act.per >= CNT_W'(2)) && (cnt < act.high);

  // commit scheduling
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      pend_s <= 1'b0;
      settle <= '0;
    end else begin
      trig_d <= trig;
      if (rise) begin
        pend_s <= smooth;
        settle <= smooth ? '0 : SW'(SETTLE_CYC);
      end else if (commit) begin
        pend_s <= 1'b0;
        settle <= '0;
      end else if (settle != '0) begin
        settle <= settle - 1'b1;
      end
    end
  end

  // active copy and waveform counters
  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      pcnt <= '0;
      cnt  <= '0;
    end else if (commit) begin
      act  <= shadow;
      pcnt <= '0;
      cnt  <= '0;
    end else if (tick) begin
      pcnt <= '0;
      cnt  <= boundary ? '0 : nxt[CNT_W-1:0];
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_comb level = forced ? 1'b1 : (act.pol ? active : ~active);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= level;
      oe_q  <= otype | ~level;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int ADDR_W     = 8,
  parameter int SETTLE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic [NCH-1:0]    pwm_oe
);
  logic [NCH-1:0] ctrl_trig, ctrl_pol, ctrl_type, ctrl_smooth;
  chan_cfg_t      shadow [NCH];

  pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig(ctrl_trig), .pol(ctrl_pol), .otype(ctrl_type),
    .smooth(ctrl_smooth), .shadow(shadow)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_bank_chan #(.SETTLE_CYC(SETTLE_CYC)) u_chan (
      .clk(clk), .rst(rst), .shadow(shadow[c]),
      .trig(ctrl_trig[c]), .smooth(ctrl_smooth[c]), .otype(ctrl_type[c]),
      .pin_q(pwm_out[c]), .oe_q(pwm_oe[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    pwm_oe,
  input logic [NCH-1:0]    trig,
  input logic [NCH-1:0]    pol,
  input logic [NCH-1:0]    otype,
  input logic [NCH-1:0]    smooth
);
  assert_forced_high_R6: assert property (@(posedge clk) disable iff (rst)
    (&(pwm_out | $past(smooth | trig))));

  assert_od_release_R10: assert property (@(posedge clk) disable iff (rst)
    ((pwm_oe & pwm_out & ~$past(otype)) == '0));

  assert_pp_drive_R10: assert property (@(posedge clk) disable iff (rst)
    ((~pwm_oe & $past(otype)) == '0));

  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0) |=>
      (trig == $past(wdata[0 +: NCH]) && pol == $past(wdata[8 +: NCH]) &&
       otype == $past(wdata[16 +: NCH]) && smooth == $past(wdata[24 +: NCH])));

  assert_reset_pins_R11: assert property (@(posedge clk)
    rst |=> ((&pwm_out) && (pwm_oe == '0)));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe), .trig(ctrl_trig), .pol(ctrl_pol),
  .otype(ctrl_type), .smooth(ctrl_smooth)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int NCH = 6;
  localparam int S   = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire  [NCH-1:0] pwm_out, pwm_oe;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ctrl_img = '0, pre_img = '0, rv;

  always #10 clk = ~clk;

  pwm_bank #(.NCH(NCH), .ADDR_W(8), .SETTLE_CYC(S)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic ones(input int c, input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      k += int'(pwm_out[c]);
    end
  endtask

  // stage shadow values, then commit with a fast trigger
  task automatic set_chan(input int c, input int pre, input int per, input int high, input bit pl);
    ctrl_img[24+c] = 1'b1; ctrl_img[c] = 1'b0;
    wr(8'h00, ctrl_img);
    pre_img[4*c +: 3] = 3'(pre);
    wr(8'h04, pre_img);
    wr(8'(8 + 8*c), 32'(per));
    wr(8'(12 + 8*c), 32'(high));
    ctrl_img[8+c] = pl; ctrl_img[24+c] = 1'b0; ctrl_img[c] = 1'b1;
    wr(8'h00, ctrl_img);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int k, idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 pins", 32'(pwm_out), 32'h3F);
    check("R11 oe", 32'(pwm_oe), 32'h0);
    rd(8'h00, rv); check("R11 ctrl", rv, 32'h0);

    // R1 / R2 register map
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, rv); check("R1 ctrl mask", rv, 32'h3F3F_3F3F);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, rv); check("R2 prescale", rv, 32'h0077_7777);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, rv); check("R2 period ch3", rv, 32'h00FF_FFFF);
    wr(8'h34, 32'h1234_5678); rd(8'h34, rv); check("R2 high ch5", rv, 32'h0034_5678);
    rd(8'h3C, rv); check("R2 unmapped", rv, 32'h0);
    wr(8'h04, 32'h0); wr(8'h20, 32'h0); wr(8'h34, 32'h0);
    ctrl_img = 32'h003F_0000;
    wr(8'h00, ctrl_img);

    // R7 R8 R9 sweep
    idx = 0;
    for (int pre = 0; pre < 3; pre++) begin
      for (int pi = 0; pi < 5; pi++) begin
        int per;
        per = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 2 : (pi == 3) ? 3 : 5;
        for (int h = 0; h <= per + 1; h++) begin
          int c, w, a, e;
          bit pl;
          c = idx % NCH; pl = (idx % 3) != 2; idx++;
          set_chan(c, pre, per, h, pl);
          repeat (S + 4) @(negedge clk);
          w = 2 * (pre + 1) * ((per < 2) ? 2 : per);
          a = (per < 2) ? 0 : 2 * (pre + 1) * ((h < per) ? h : per);
          e = pl ? a : w - a;
          ones(c, w, k);
          check(pl ? "R7 duty" : "R8 inverted duty", 32'(k), 32'(e));
        end
      end
    end

    // R4 fast commit timing on channel 1
    set_chan(1, 0, 0, 0, 1'b1);
    repeat (S + 4) @(negedge clk);
    check("R9 idle low", 32'(pwm_out[1]), 32'h0);
    ctrl_img[25] = 1'b1; ctrl_img[1] = 1'b0; wr(8'h00, ctrl_img);
    wr(8'h10, 32'd4); wr(8'h14, 32'd9);
    ctrl_img[25] = 1'b0; ctrl_img[1] = 1'b1; wr(8'h00, ctrl_img);
    repeat (S + 1) @(negedge clk);
    check("R4 old before edge", 32'(pwm_out[1]), 32'h0);
    @(negedge clk);
    check("R4 new at edge", 32'(pwm_out[1]), 32'h1);

    // R3 and R5 on channel 2
    set_chan(2, 0, 100, 60, 1'b1);
    repeat (S + 4) @(negedge clk);
    ctrl_img[26] = 1'b1; ctrl_img[2] = 1'b0; wr(8'h00, ctrl_img);
    wr(8'h18, 32'd0); wr(8'h1C, 32'd0);
    ones(2, 200, k);
    check("R3 shadow held", 32'(k), 32'd120);
    ctrl_img[2] = 1'b1; wr(8'h00, ctrl_img);   // rise, no shadow change since
    ctrl_img[2] = 1'b1; wr(8'h00, ctrl_img);   // level held high
    repeat (150) @(negedge clk);               // wait out the commit
    check("R5 idle after commit", 32'(pwm_out[2]), 32'h0);
    set_chan(2, 0, 100, 60, 1'b1);
    repeat (S + 4) @(negedge clk);
    ctrl_img[26] = 1'b1; ctrl_img[2] = 1'b0; wr(8'h00, ctrl_img);
    wr(8'h18, 32'd0); wr(8'h1C, 32'd0);
    while (pwm_out[2] !== 1'b0) @(negedge clk);
    while (pwm_out[2] !== 1'b1) @(negedge clk);
    ctrl_img[2] = 1'b1; wr(8'h00, ctrl_img);
    repeat (38) @(negedge clk);
    check("R5 old waveform kept", 32'(pwm_out[2]), 32'h1);
    repeat (31) @(negedge clk);
    check("R5 old low phase", 32'(pwm_out[2]), 32'h0);
    repeat (80) @(negedge clk);
    check("R5 committed at boundary", 32'(pwm_out[2]), 32'h0);

    // R6 forced high on channel 4
    set_chan(4, 0, 10, 5, 1'b1);
    repeat (S + 4) @(negedge clk);
    ctrl_img[28] = 1'b0; ctrl_img[4] = 1'b0; wr(8'h00, ctrl_img);
    ones(4, 20, k);
    check("R6 forced high", 32'(k), 32'd20);

    // R10 drive type on channel 0
    set_chan(0, 0, 0, 0, 1'b1);
    repeat (S + 4) @(negedge clk);
    check("R10 pp low", {30'd0, pwm_out[0], pwm_oe[0]}, 32'b01);
    ctrl_img[16] = 1'b0; wr(8'h00, ctrl_img); @(negedge clk);
    check("R10 od low", {30'd0, pwm_out[0], pwm_oe[0]}, 32'b01);
    ctrl_img[24] = 1'b0; ctrl_img[0] = 1'b0; wr(8'h00, ctrl_img); @(negedge clk);
    check("R10 od high", {30'd0, pwm_out[0], pwm_oe[0]}, 32'b10);
    ctrl_img[16] = 1'b1; wr(8'h00, ctrl_img); @(negedge clk);
    check("R10 pp high", {30'd0, pwm_out[0], pwm_oe[0]}, 32'b11);

    report();
  end
endmodule